// File: doc/BRIEF.md
# SDRAM Command-Level Device Model

This block acts as the memory chip on the far side of a single-data-rate SDRAM controller. It watches the controller's pins on every rising clock edge, decodes the command carried by the three strobes, keeps track of which bank is open and on which row, and holds the data in a word array small enough for on-chip RAM. It is meant for testbenches and for emulation on a chip, where a real device is not available but the controller's command stream still has to be served.

Reads place the addressed word into a short delay line. The word appears on the read data bus after the column-access latency that the last mode register load selected. Misuse of the protocol is signalled on separate one-cycle flags, one cycle after the offending command: an undefined code, opening a bank that is already open, touching a closed bank, asking for auto-precharge, a wrong data-bus direction, and reserved mode bits.

Refresh timing, auto-precharge, bursts longer than one word and electrical timing are outside its scope.

Top module: `sdram_device_model`

## Requirements
- R1: A command is taken only at a rising edge where `cs_n` is 0 and `cke` was 1 at the previous rising edge; any other edge changes no state and raises no flag.
- R2: The command code is `{ras_n, cas_n, we_n}`: 0 mode load, 1 self refresh (no effect), 2 precharge, 3 activate, 4 write, 5 read, 7 no-op. Code 6 pulses `err_cmd` for one cycle after the edge.
- R3: After reset the read latency is 3. A mode load with `ba` = 0 and `addr[10]` = 0 sets the latency to `addr[6:4]`; a mode load with any other `ba` or with `addr[10]` = 1 leaves it unchanged.
- R4: A mode load that is applied pulses `warn_mode` when any of `addr[9:7]` or `addr[3]` is 1.
- R5: Activate opens bank `ba` at row `addr[ROW_BITS-1:0]`; activating an open bank pulses `err_reopen`.
- R6: Precharge with `addr[10]` = 1 closes every bank; with `addr[10]` = 0 it closes only bank `ba`.
- R7: A write to an open bank stores byte lane i of `dq_wr` (bits 8i+7..8i) for each lane where `dqm[i]` is 0 into word {bank, open row, `addr[COL_BITS-1:0]`}; lanes with `dqm[i]` = 1 keep their value.
- R8: A read at edge T with latency L (2 or 3) shows the stored word on `dq_rd` between edges T+L-1 and T+L.
- R9: A read or write to a closed bank pulses `err_closed`; such a write stores nothing and such a read returns zero.
- R10: A read or write with `addr[10]` = 1 pulses `err_autopre` and is still carried out as a plain access.
- R11: A write with `dq_oe` = 0, or a read with `dq_oe` = 1, pulses `err_dir` and is still carried out.
- R12: While the latency is neither 2 nor 3, `dq_rd` is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable from the controller |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, command bit 2 |
| cas_n | input | 1 | Column strobe, command bit 1 |
| we_n | input | 1 | Write strobe, command bit 0 |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Multiplexed row / column / mode address |
| dqm | input | LANES | Per-lane write mask, 1 masks the lane |
| dq_wr | input | 8*LANES | Data driven by the controller |
| dq_oe | input | 1 | Controller is driving the data bus |
| dq_rd | output | 8*LANES | Data returned by the device |
| err_cmd | output | 1 | Undefined command seen |
| err_reopen | output | 1 | Activate on an open bank |
| err_closed | output | 1 | Access to a closed bank |
| err_autopre | output | 1 | Auto-precharge requested |
| err_dir | output | 1 | Data-bus direction wrong for the access |
| warn_mode | output | 1 | Reserved mode bits set |

## Verification
The bench fills and reads back every word of a reduced array at both supported latencies, so a design that mixed up bank, row or column in the word address would return another word's pattern, and one that sampled the delay line one stage off would show the previous read's data. It aims at the gating of commands by the clock enable of the previous edge, where a design that looked at the current `cke` would accept a command one cycle early. Single-bank against all-bank precharge, partial lane masks, writes to closed banks that must leave memory unchanged, and mode loads that must be ignored are each driven on their own, as is an unsupported latency that must silence the read bus.

// File: rtl/sdram_dev_pkg.sv
package sdram_dev_pkg;

  typedef enum logic [2:0] {
    CMD_MODE  = 3'd0,
    CMD_SREF  = 3'd1,
    CMD_PRE   = 3'd2,
    CMD_ACT   = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_READ  = 3'd5,
    CMD_UNDEF = 3'd6,
    CMD_NOP   = 3'd7
  } sdram_cmd_e;

  localparam int unsigned LAT_RESET = 3;

  // only two delay-line taps exist
  function automatic logic lat_supported(input logic [2:0] lat);
    return (lat == 3'd2) || (lat == 3'd3);
  endfunction

  // reserved mode bits: 9..7 and 3
  function automatic logic mode_reserved(input logic [10:0] a);
    return |(a & 11'h388);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_dev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output logic       accept,
  output sdram_cmd_e cmd
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  assign accept = !cs_n && cke_q;
  assign cmd    = sdram_cmd_e'({ras_n, cas_n, we_n});
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int BANKS    = 4,
  parameter int ROW_BITS = 6,
  parameter int BA_W     = $clog2(BANKS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act,
  input  logic                      pre,
  input  logic                      pre_all,
  input  logic [BA_W-1:0]           ba,
  input  logic [ROW_BITS-1:0]       row_in,
  output logic [BANKS-1:0]          open_vec,
  output logic [BANKS*ROW_BITS-1:0] row_flat
);
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic                hit;
    logic [ROW_BITS-1:0] row_q;
    assign hit = (ba == BA_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vec[g] <= 1'b0;
        row_q       <= '0;
      end else if (act && hit) begin
        open_vec[g] <= 1'b1;
        row_q       <= row_in;
      end else if (pre && (pre_all || hit)) begin
        open_vec[g] <= 1'b0;
      end
    end

    assign row_flat[g*ROW_BITS +: ROW_BITS] = row_q;
  end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe
  import sdram_dev_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lat_set,
  input  logic [2:0]    lat_val,
  output logic [2:0]    lat,
  output logic [DW-1:0] dq_rd
);
  localparam int STAGES = 3;

  logic [DW-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
      lat <= 3'(LAT_RESET);
    end else begin
      if (load) stage[0] <= load_data;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      if (lat_set) lat <= lat_val;
    end
  end

  // tap L-1 is the word loaded L-1 edges ago
  always_comb begin
    if (!lat_supported(lat)) dq_rd = '0;
    else if (lat == 3'd2)    dq_rd = stage[1];
    else                     dq_rd = stage[2];
  end
endmodule

// File: rtl/sdram_device_model.sv
module sdram_device_model
  import sdram_dev_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int LANES    = 2,
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = $clog2(BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     dqm,
  input  logic [8*LANES-1:0]   dq_wr,
  input  logic                 dq_oe,
  output logic [8*LANES-1:0]   dq_rd,
  output logic                 err_cmd,
  output logic                 err_reopen,
  output logic                 err_closed,
  output logic                 err_autopre,
  output logic                 err_dir,
  output logic                 warn_mode
);
  localparam int DW     = 8 * LANES;
  localparam int MEM_AW = BA_W + ROW_BITS + COL_BITS;
  localparam int DEPTH  = 1 << MEM_AW;

  // named internal events
  logic       cmd_accept;
  sdram_cmd_e cmd;
  logic       is_mode, mode_apply, is_pre, is_act, is_wr, is_rd;
  logic       a10;
  logic [BANKS-1:0]          open_vec;
  logic [BANKS*ROW_BITS-1:0] row_flat;
  logic                      sel_open;
  logic [ROW_BITS-1:0]       sel_row;
  logic [MEM_AW-1:0]         word_idx;
  logic                      wr_store;
  logic [DW-1:0]             rd_word;
  logic [2:0]                cas_lat;
  logic                      unused_addr_bits;

  sdram_cmd_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .accept (cmd_accept),
    .cmd    (cmd)
  );

  assign a10        = addr[10];
  assign is_mode    = cmd_accept && (cmd == CMD_MODE);
  assign mode_apply = is_mode && (ba == '0) && !a10;
  assign is_pre     = cmd_accept && (cmd == CMD_PRE);
  assign is_act     = cmd_accept && (cmd == CMD_ACT);
  assign is_wr      = cmd_accept && (cmd == CMD_WRITE);
  assign is_rd      = cmd_accept && (cmd == CMD_READ);
  assign unused_addr_bits = ^addr;

  sdram_bank_state #(
    .BANKS    (BANKS),
    .ROW_BITS (ROW_BITS),
    .BA_W     (BA_W)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (is_act),
    .pre      (is_pre),
    .pre_all  (a10),
    .ba       (ba),
    .row_in   (addr[ROW_BITS-1:0]),
    .open_vec (open_vec),
    .row_flat (row_flat)
  );

  assign sel_open = open_vec[ba];
  assign sel_row  = row_flat[ba*ROW_BITS +: ROW_BITS];
  assign word_idx = {ba, sel_row, addr[COL_BITS-1:0]};
  assign wr_store = is_wr && sel_open;

  // word array, one write port with lane masks
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_store) begin
      for (int i = 0; i < LANES; i++) begin
        if (!dqm[i]) mem[word_idx][8*i +: 8] <= dq_wr[8*i +: 8];
      end
    end
  end

  assign rd_word = sel_open ? mem[word_idx] : '0;

  sdram_read_pipe #(.DW(DW)) u_rpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (is_rd),
    .load_data (rd_word),
    .lat_set   (mode_apply),
    .lat_val   (addr[6:4]),
    .lat       (cas_lat),
    .dq_rd     (dq_rd)
  );

  // protocol flags, one cycle after the command
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cmd     <= 1'b0;
      err_reopen  <= 1'b0;
      err_closed  <= 1'b0;
      err_autopre <= 1'b0;
      err_dir     <= 1'b0;
      warn_mode   <= 1'b0;
    end else begin
      err_cmd     <= cmd_accept && (cmd == CMD_UNDEF);
      err_reopen  <= is_act && sel_open;
      err_closed  <= (is_wr || is_rd) && !sel_open;
      err_autopre <= (is_wr || is_rd) && a10;
      err_dir     <= (is_wr && !dq_oe) || (is_rd && dq_oe);
      warn_mode   <= mode_apply && mode_reserved(addr[10:0]);
    end
  end
endmodule

// File: rtl/sdram_device_model_checker.sv
module sdram_device_model_checker #(
  parameter int BANKS = 4,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_accept,
  input logic [2:0]       cmd_code,
  input logic             mode_apply,
  input logic             is_act,
  input logic             is_pre,
  input logic             a10,
  input logic             ba_zero,
  input logic [2:0]       cas_lat,
  input logic [BANKS-1:0] open_vec,
  input logic [DW-1:0]    dq_rd,
  input logic             err_cmd,
  input logic             err_reopen,
  input logic             err_closed,
  input logic             err_autopre,
  input logic             err_dir,
  input logic             warn_mode
);
  assert_no_flag_unaccepted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_accept |=> !(err_cmd || err_reopen || err_closed || err_autopre || err_dir || warn_mode));

  assert_undef_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |-> $past(cmd_code) == 3'd6);

  assert_latency_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_apply |=> $stable(cas_lat));

  assert_activate_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && ba_zero) |=> open_vec[0]);

  assert_precharge_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |=> (open_vec == '0));

  assert_silent_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !((cas_lat == 3'd2) || (cas_lat == 3'd3)) |-> (dq_rd == '0));
endmodule

bind sdram_device_model sdram_device_model_checker #(
  .BANKS (BANKS),
  .DW    (8*LANES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_accept  (cmd_accept),
  .cmd_code    (cmd),
  .mode_apply  (mode_apply),
  .is_act      (is_act),
  .is_pre      (is_pre),
  .a10         (a10),
  .ba_zero     (ba == '0),
  .cas_lat     (cas_lat),
  .open_vec    (open_vec),
  .dq_rd       (dq_rd),
  .err_cmd     (err_cmd),
  .err_reopen  (err_reopen),
  .err_closed  (err_closed),
  .err_autopre (err_autopre),
  .err_dir     (err_dir),
  .warn_mode   (warn_mode)
);

// File: tb/sdram_device_model_bench.sv
module sdram_device_model_bench;
  localparam int BANKS = 4, LANES = 2, ROW_BITS = 2, COL_BITS = 2, ADDR_W = 13, BA_W = 2;
  localparam int DW = 8 * LANES;
  localparam int NROW = 1 << ROW_BITS, NCOL = 1 << COL_BITS;

  // flag vector {err_cmd, err_reopen, err_closed, err_autopre, err_dir, warn_mode}
  localparam logic [5:0] F_NONE = 6'b000000, F_CMD = 6'b100000, F_REOPEN = 6'b010000,
                         F_CLOSED = 6'b001000, F_AUTO = 6'b000100, F_DIR = 6'b000010,
                         F_WARN = 6'b000001;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  dqm;
  logic [DW-1:0]     dq_wr, dq_rd;
  logic err_cmd, err_reopen, err_closed, err_autopre, err_dir, warn_mode;
  logic [5:0] flags;
  assign flags = {err_cmd, err_reopen, err_closed, err_autopre, err_dir, warn_mode};

  sdram_device_model #(
    .BANKS(BANKS), .LANES(LANES), .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS), .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) u_sdram_device_model (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .dq_wr(dq_wr), .dq_oe(dq_oe),
    .dq_rd(dq_rd), .err_cmd(err_cmd), .err_reopen(err_reopen), .err_closed(err_closed),
    .err_autopre(err_autopre), .err_dir(err_dir), .warn_mode(warn_mode)
  );

  int checks = 0, failures = 0;
  int cur_lat = 3;
  logic [DW-1:0] model [BANKS*NROW*NCOL];

  function automatic int widx(int b, int r, int c);
    return (b * NROW + r) * NCOL + c;
  endfunction

  function automatic logic [DW-1:0] pat(int b, int r, int c);
    return 16'((b * 4099 + r * 257 + c * 31 + 17) & 16'hffff) ^ 16'h5a00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one command at a falling edge, return after the next falling edge
  task automatic issue(logic [2:0] code, int b, logic [ADDR_W-1:0] a,
                       logic [LANES-1:0] m = '1, logic [DW-1:0] d = '0,
                       logic oe = 1'b0, logic sel_n = 1'b0, logic ck = 1'b1);
    {ras_n, cas_n, we_n} = code;
    cs_n = sel_n; cke = ck; ba = BA_W'(b); addr = a; dqm = m; dq_wr = d; dq_oe = oe;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) issue(3'd7, 0, '0);
  endtask

  task automatic do_read(string req, int b, logic [ADDR_W-1:0] a, logic oe,
                         logic [5:0] expf, logic [DW-1:0] expd);
    issue(3'd5, b, a, '0, '0, oe);
    check(req, 32'(flags), 32'(expf), "read flags");
    idle(cur_lat - 1);
    check(req, 32'(dq_rd), 32'(expd), "read data at latency");
  endtask

  task automatic do_write(string req, int b, int r, int c, logic [ADDR_W-1:0] extra,
                          logic [LANES-1:0] m, logic [DW-1:0] d, logic oe, logic [5:0] expf);
    issue(3'd4, b, extra | ADDR_W'(c), m, d, oe);
    check(req, 32'(flags), 32'(expf), "write flags");
    if (expf[3] == 1'b0) begin
      for (int i = 0; i < LANES; i++)
        if (!m[i]) model[widx(b, r, c)][8*i +: 8] = d[8*i +: 8];
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'd7;
    ba = '0; addr = '0; dqm = '1; dq_wr = '0; dq_oe = 1'b0;
    repeat (3) @(negedge clk);
    check("R3", 32'(flags), 32'(F_NONE), "flags in reset");
    check("R12", 32'(dq_rd), 0, "read bus in reset");
    rst_n = 1'b1;
    idle(2);

    // R1: deselected and clock-enable gating
    issue(3'd6, 0, '0, '1, '0, 1'b0, 1'b1);
    check("R1", 32'(flags), 32'(F_NONE), "deselected undefined code");
    issue(3'd7, 0, '0, '1, '0, 1'b0, 1'b0, 1'b0);
    issue(3'd6, 0, '0);
    check("R1", 32'(flags), 32'(F_NONE), "cke low at previous edge");
    issue(3'd6, 0, '0);
    check("R2", 32'(flags), 32'(F_CMD), "undefined code flagged");
    issue(3'd1, 0, '0);
    check("R2", 32'(flags), 32'(F_NONE), "self refresh ignored");

    // R7/R8: full sweep at the reset latency of 3
    for (int b = 0; b < BANKS; b++)
      for (int r = 0; r < NROW; r++) begin
        issue(3'd3, b, ADDR_W'(r));
        check("R5", 32'(flags), 32'(F_NONE), "activate closed bank");
        for (int c = 0; c < NCOL; c++)
          do_write("R7", b, r, c, '0, '0, pat(b, r, c), 1'b1, F_NONE);
        for (int c = 0; c < NCOL; c++)
          do_read("R8", b, ADDR_W'(c), 1'b0, F_NONE, model[widx(b, r, c)]);
        issue(3'd2, b, '0);
      end

    // R3: latency 2, then sweep again
    issue(3'd0, 0, 13'h020);
    check("R3", 32'(flags), 32'(F_NONE), "mode load flags");
    cur_lat = 2;
    for (int b = 0; b < BANKS; b++)
      for (int r = 0; r < NROW; r++) begin
        issue(3'd3, b, ADDR_W'(r));
        for (int c = 0; c < NCOL; c++)
          do_read("R8", b, ADDR_W'(c), 1'b0, F_NONE, model[widx(b, r, c)]);
        issue(3'd2, b, '0);
      end

    // R3: ignored mode loads keep latency 2
    issue(3'd0, 1, 13'h030);
    issue(3'd0, 0, 13'h430);
    issue(3'd3, 0, 13'h000);
    do_read("R3", 0, 13'h000, 1'b0, F_NONE, model[widx(0, 0, 0)]);

    // R4: reserved bits
    issue(3'd0, 0, 13'h0A0);
    check("R4", 32'(flags), 32'(F_WARN), "bit 7 set");
    issue(3'd0, 0, 13'h038);
    check("R4", 32'(flags), 32'(F_WARN), "bit 3 set");
    issue(3'd0, 0, 13'h030);
    check("R4", 32'(flags), 32'(F_NONE), "clean mode load");
    cur_lat = 3;
    do_read("R3", 0, 13'h001, 1'b0, F_NONE, model[widx(0, 0, 1)]);

    // R12: unsupported latency silences the bus
    issue(3'd0, 0, 13'h050);
    issue(3'd5, 0, 13'h002);
    for (int k = 0; k < 3; k++) begin
      check("R12", 32'(dq_rd), 0, "latency 5 bus");
      idle(1);
    end
    issue(3'd0, 0, 13'h030);

    // R7: lane masks on bank 0 row 0
    do_write("R7", 0, 0, 0, '0, 2'b01, 16'hBEEF, 1'b1, F_NONE);
    do_read("R7", 0, 13'h000, 1'b0, F_NONE, model[widx(0, 0, 0)]);
    do_write("R7", 0, 0, 0, '0, 2'b10, 16'h1234, 1'b1, F_NONE);
    do_write("R7", 0, 0, 0, '0, 2'b11, 16'hFFFF, 1'b1, F_NONE);
    do_read("R7", 0, 13'h000, 1'b0, F_NONE, model[widx(0, 0, 0)]);

    // R10: auto-precharge flagged, access performed
    do_write("R10", 0, 0, 1, 13'h400, '0, 16'hA55A, 1'b1, F_AUTO);
    do_read("R10", 0, 13'h401, 1'b0, F_AUTO, 16'hA55A);

    // R11: direction errors
    do_write("R11", 0, 0, 2, '0, '0, 16'h0FF0, 1'b0, F_DIR);
    do_read("R11", 0, 13'h002, 1'b1, F_DIR, 16'h0FF0);

    // R5: reopen
    issue(3'd3, 0, 13'h000);
    check("R5", 32'(flags), 32'(F_REOPEN), "activate open bank");
    issue(3'd2, 0, '0);

    // R6 / R9: single and all-bank precharge
    issue(3'd3, 1, 13'h001);
    issue(3'd3, 2, 13'h002);
    issue(3'd2, 1, 13'h000);
    do_read("R9", 1, 13'h000, 1'b0, F_CLOSED, '0);
    do_read("R6", 2, 13'h000, 1'b0, F_NONE, model[widx(2, 2, 0)]);
    issue(3'd2, 0, 13'h400);
    do_read("R6", 2, 13'h001, 1'b0, F_CLOSED, '0);
    issue(3'd3, 2, 13'h002);
    check("R6", 32'(flags), 32'(F_NONE), "reactivate after all-bank precharge");

    // R9: write to a closed bank stores nothing
    issue(3'd2, 2, 13'h000);
    do_write("R9", 2, 2, 3, '0, '0, 16'hDEAD, 1'b1, F_CLOSED);
    issue(3'd3, 2, 13'h002);
    do_read("R9", 2, 13'h003, 1'b0, F_NONE, model[widx(2, 2, 3)]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule